// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Format Register

This block turns bytes written by a processor into asynchronous serial characters on a single output wire. Software writes a byte-wide line format register that chooses the number of data bits (5 to 8), the number of stop bits, and whether a parity bit is sent. A parity bit, when present, is even, odd or held at a fixed level. The same register carries a break control that holds the wire low, and an access-select bit. The access-select bit re-routes the data and interrupt-enable addresses to a 16-bit baud divisor. The divisor is driven out to an external baud generator, which returns one `baud_tick` pulse per sixteenth of a bit time.

A character is queued by writing the transmit holding register. The transmitter moves it into its shift register as soon as the line is free, or directly at the end of the previous stop period, so back-to-back characters leave no idle gap. The format is captured when a character starts. Break only masks the output wire, so the character timing underneath runs on unchanged.

Top module: `uart_line_tx`

## Requirements
- R1: After reset `txd` is 1, `thr_empty` is 1, `tx_busy` is 0, and the format register (address 3) and divisor read back as 0.
- R2: The format register at address 3 reads back the last value written to it, at any access-select setting.
- R3: With format bit 7 set to 1, writes to address 0 set the low divisor byte and writes to address 1 set the high divisor byte. Both read back at the same addresses and appear on `divisor`, and no character is queued.
- R4: With format bit 7 set to 0, a write to address 0 fills the holding register (`thr_empty` falls), and address 1 is an 8-bit interrupt-enable register that reads back its value.
- R5: A character is a start bit of 0, then the data bits LSB first, with the count chosen by format bits 1:0 (00=5, 01=6, 10=7, 11=8). Each bit lasts 16 baud ticks.
- R6: With format bit 3 = 1 and bit 5 = 0, a parity bit follows the data. It makes the count of ones even when bit 4 = 1 and odd when bit 4 = 0.
- R7: With format bits 3 and 5 both 1, the parity bit is the inverse of bit 4.
- R8: Format bit 2 = 0 gives a 16-tick stop period. Bit 2 = 1 gives 24 ticks for 5-bit words and 32 ticks for other word lengths.
- R9: Format bit 6 = 1 holds `txd` at 0 whether idle or mid-character. The character timing is unaffected, so `tx_busy` falls at the same cycle as without break.
- R10: If the holding register is full when a stop period ends, the next start bit begins on the following tick. `thr_empty` rises when a byte is moved to the shift register.
- R11: The format is captured at the start of each character. A format write during a character affects only later characters, except for break.
- R12: With no character in progress and break off, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| baud_tick | input | 1 | One pulse per 1/16 bit time |
| txd | output | 1 | Serial output, idle high |
| thr_empty | output | 1 | Holding register can accept a byte |
| tx_busy | output | 1 | A character is being shifted out |
| divisor | output | 16 | Baud divisor for the external generator |

## Verification
A format register write can land in the same cycle as a character in flight. A holding-register write can land in the same cycle that the transmitter takes the previous byte at the end of a stop period. The bench provokes the first by setting break and changing the parity and length fields mid-character. It then checks that `tx_busy` still falls exactly one old-format frame length after the start edge, and that the next character carries the new format. The second is provoked by refilling the holding register during every character of a sweep over all 64 format settings. That run is judged by requiring the next start edge exactly one computed frame length after the previous one.

// File: rtl/uart_line_pkg.sv
// Package: shared types and register addresses for the serial transmitter.
// Assumes an 8-bit register port with at most eight addresses.
package uart_line_pkg;
    localparam logic [2:0] ADDR_DATA = 3'd0;   // holding register / divisor low
    localparam logic [2:0] ADDR_IER  = 3'd1;   // interrupt enable / divisor high
    localparam logic [2:0] ADDR_FMT  = 3'd3;   // line format register

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_e;

    // Character format fields, packed in register bit order (bit 5 down to 0)
    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       long_stop;
        logic [1:0] wlen;
    } char_fmt_t;
endpackage

// File: rtl/uart_line_regs.sv
// Module: register file for the transmitter.
// Holds the format register, interrupt-enable byte and baud divisor, and
// decodes holding-register writes. Format bit 7 re-routes addresses 0 and 1
// to the divisor. Reads are combinational; the receive buffer is absent and
// reads as zero.
module uart_line_regs
    import uart_line_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [7:0]  fmt_q,
    output logic [15:0] divisor,
    output logic        thr_wr
);
    logic [7:0] ier_q;
    logic [7:0] div_lo_q;
    logic [7:0] div_hi_q;
    logic       sel_div;

    assign sel_div = fmt_q[7];
    assign divisor = {div_hi_q, div_lo_q};
    assign thr_wr  = wr_en && (addr == ADDR_DATA) && !sel_div;

    // Register writes, routed by the access-select bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q    <= '0;
            ier_q    <= '0;
            div_lo_q <= '0;
            div_hi_q <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_FMT:  fmt_q <= wdata;
                ADDR_DATA: if (sel_div) div_lo_q <= wdata;
                ADDR_IER:  if (sel_div) div_hi_q <= wdata;
                           else         ier_q    <= wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        case (addr)
            ADDR_FMT:  rdata = fmt_q;
            ADDR_DATA: rdata = sel_div ? div_lo_q : 8'h00;
            ADDR_IER:  rdata = sel_div ? div_hi_q : ier_q;
            default:   rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/uart_tx_frame.sv
// Module: holding register and character shifter.
// Captures the format and parity when a byte moves to the shift register,
// then sends start, data (LSB first), optional parity and stop. Each bit
// lasts TICKS_PER_BIT baud ticks. TICKS_PER_BIT is assumed even, so that a
// stop period of one and a half bits is a whole number of ticks.
module uart_tx_frame
    import uart_line_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      baud_tick,
    input  logic      thr_wr,
    input  logic [7:0] thr_wdata,
    input  char_fmt_t fmt_in,
    output logic      thr_empty,
    output logic      busy,
    output logic      line_bit
);
    localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] LAST_1   = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] LAST_1H  = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_2   = CNT_W'(2 * TICKS_PER_BIT - 1);

    tx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_last;
    logic [7:0]       thr_q;
    logic             thr_full_q;
    logic [7:0]       shift_q;
    logic [2:0]       idx_q;
    logic [2:0]       idx_last;
    char_fmt_t        fmt_q;
    logic             par_q;
    logic             par_calc;
    logic [7:0]       masked;
    logic             bit_end;
    logic             take;

    // Parity of the queued byte, masked to the selected word length
    always_comb begin
        masked   = thr_q & (8'hFF >> (2'd3 - fmt_in.wlen));
        if (fmt_in.stick) par_calc = !fmt_in.even;
        else              par_calc = fmt_in.even ? ^masked : !(^masked);
    end

    // Length of the current bit period, longer for extended stop
    always_comb begin
        if (state_q != TX_STOP || !fmt_q.long_stop) cnt_last = LAST_1;
        else if (fmt_q.wlen == 2'b00)               cnt_last = LAST_1H;
        else                                        cnt_last = LAST_2;
    end

    assign idx_last  = 3'd4 + {1'b0, fmt_q.wlen};
    assign bit_end   = baud_tick && (cnt_q == cnt_last) && (state_q != TX_IDLE);
    assign take      = thr_full_q && ((state_q == TX_IDLE) || (state_q == TX_STOP && bit_end));
    assign thr_empty = !thr_full_q;
    assign busy      = (state_q != TX_IDLE);

    // Holding register: a new write wins over a same-cycle transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q      <= '0;
            thr_full_q <= 1'b0;
        end else if (thr_wr) begin
            thr_q      <= thr_wdata;
            thr_full_q <= 1'b1;
        end else if (take) begin
            thr_full_q <= 1'b0;
        end
    end

    // Character sequencer and tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            idx_q   <= '0;
            fmt_q   <= '0;
            par_q   <= 1'b0;
        end else if (take) begin
            state_q <= TX_START;
            cnt_q   <= '0;
            shift_q <= thr_q;
            idx_q   <= '0;
            fmt_q   <= fmt_in;
            par_q   <= par_calc;
        end else if (bit_end) begin
            cnt_q <= '0;
            case (state_q)
                TX_START: state_q <= TX_DATA;
                TX_DATA: begin
                    shift_q <= shift_q >> 1;
                    if (idx_q == idx_last) state_q <= fmt_q.par_en ? TX_PAR : TX_STOP;
                    else                   idx_q   <= idx_q + 3'd1;
                end
                TX_PAR:  state_q <= TX_STOP;
                default: state_q <= TX_IDLE;
            endcase
        end else if (baud_tick && state_q != TX_IDLE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Line level for the current bit
    always_comb begin
        case (state_q)
            TX_START: line_bit = 1'b0;
            TX_DATA:  line_bit = shift_q[0];
            TX_PAR:   line_bit = par_q;
            default:  line_bit = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_line_tx.sv
// Module: top of the serial transmitter.
// Joins the register file and the shifter. Break (format bit 6) masks only
// the output wire. Assumes baud_tick comes from a generator run from divisor.
module uart_line_tx
    import uart_line_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        baud_tick,
    output logic        txd,
    output logic        thr_empty,
    output logic        tx_busy,
    output logic [15:0] divisor
);
    logic [7:0] lcr_q;
    logic       thr_wr;
    logic       line_bit;

    uart_line_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .fmt_q   (lcr_q),
        .divisor (divisor),
        .thr_wr  (thr_wr)
    );

    uart_tx_frame #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .thr_wr    (thr_wr),
        .thr_wdata (reg_wdata),
        .fmt_in    (char_fmt_t'(lcr_q[5:0])),
        .thr_empty (thr_empty),
        .busy      (tx_busy),
        .line_bit  (line_bit)
    );

    assign txd = line_bit && !lcr_q[6];
endmodule

// File: rtl/uart_line_tx_chk.sv
// Module: property checker bound to the transmitter top.
// Observes ports plus the format register output of the register file.
module uart_line_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic [7:0] fmt,
    input logic       txd,
    input logic       thr_empty,
    input logic       tx_busy
);
    logic brk;
    logic dsel;
    assign brk  = fmt[6];
    assign dsel = fmt[7];

    AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd); // R9
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !brk) |-> txd); // R12
    AST_FILL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(thr_empty) |-> $past(reg_wr && reg_addr == 3'd0 && !dsel)); // R4
    AST_DIV_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && dsel) |=> !$fell(thr_empty)); // R3
    AST_FULL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!thr_empty && !tx_busy) |=> tx_busy); // R10
endmodule

bind uart_line_tx uart_line_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .fmt       (lcr_q),
    .txd       (txd),
    .thr_empty (thr_empty),
    .tx_busy   (tx_busy)
);

// File: tb/uart_line_tx_tb.sv
// Bench: sweeps all 64 character formats with back-to-back characters,
// then access-select, break and mid-character format changes.
module uart_line_tx_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        baud_tick = 1'b1;
    logic        txd;
    logic        thr_empty;
    logic        tx_busy;
    logic [15:0] divisor;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    uart_line_tx u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .baud_tick(baud_tick),
        .txd(txd), .thr_empty(thr_empty), .tx_busy(tx_busy), .divisor(divisor)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic int nbits(input logic [7:0] f);
        return 5 + int'(f[1:0]);
    endfunction

    function automatic int frame_len(input logic [7:0] f);
        int stop;
        stop = !f[2] ? 16 : (f[1:0] == 2'b00 ? 24 : 32);
        return 16 * (1 + nbits(f) + int'(f[3])) + stop;
    endfunction

    function automatic logic exp_par(input logic [7:0] f, input logic [7:0] d);
        logic x;
        x = ^(d & (8'hFF >> (3 - int'(f[1:0]))));
        if (f[5]) return !f[4];
        return f[4] ? x : !x;
    endfunction

    // Called at the first negedge after a start edge, elapsed cycles later
    task automatic check_bits(input logic [7:0] f, input logic [7:0] d, input int elapsed);
        repeat (8 - elapsed) @(negedge clk);
        chk(txd == 1'b0, "R5 start", txd, 0);
        for (int k = 0; k < nbits(f); k++) begin
            repeat (16) @(negedge clk);
            chk(txd == d[k], "R5 data", txd, d[k]);
        end
        if (f[3]) begin
            repeat (16) @(negedge clk);
            chk(txd == exp_par(f, d), f[5] ? "R7 stick" : "R6 parity", txd, exp_par(f, d));
        end
        repeat (16) @(negedge clk);
        chk(txd == 1'b1, "R8 stop", txd, 1);
    endtask

    task automatic wait_fall(output int t);
        logic prev;
        prev = txd;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (prev && !txd) break;
            prev = txd;
        end
        t = cyc;
    endtask

    task automatic wait_empty(output int t);
        for (int i = 0; i < 4000 && !thr_empty; i++) @(negedge clk);
        t = cyc;
    endtask

    task automatic wait_idle(output int t);
        for (int i = 0; i < 4000 && tx_busy; i++) @(negedge clk);
        t = cyc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected 0", 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        int t0, t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(thr_empty == 1'b1, "R1 thr_empty", thr_empty, 1);
        chk(tx_busy == 1'b0, "R1 busy", tx_busy, 0);
        rd(3'd3, rv);
        chk(rv == 8'h00, "R1 format", rv, 0);
        chk(divisor == 16'h0, "R1 divisor", divisor, 0);

        // R3 divisor access, R2 readback with access-select set
        wr(3'd3, 8'h80);
        rd(3'd3, rv);
        chk(rv == 8'h80, "R2 readback", rv, 8'h80);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        chk(divisor == 16'h1234, "R3 divisor out", divisor, 16'h1234);
        rd(3'd0, rv);
        chk(rv == 8'h34, "R3 low read", rv, 8'h34);
        rd(3'd1, rv);
        chk(rv == 8'h12, "R3 high read", rv, 8'h12);
        repeat (4) @(negedge clk);
        chk(thr_empty && !tx_busy && txd, "R3 no char", {thr_empty, tx_busy, txd}, 3'b101);

        // R4 interrupt-enable register with access-select clear
        wr(3'd3, 8'h00);
        wr(3'd1, 8'hA5);
        rd(3'd1, rv);
        chk(rv == 8'hA5, "R4 ier read", rv, 8'hA5);
        chk(divisor == 16'h1234, "R4 divisor kept", divisor, 16'h1234);

        // R4 fill, R12 idle, break while idle R9
        wr(3'd3, 8'h40);
        chk(txd == 1'b0, "R9 idle break", txd, 0);
        wr(3'd3, 8'h00);
        chk(txd == 1'b1, "R12 idle mark", txd, 1);

        // Sweep all formats with two back-to-back characters each
        for (int f = 0; f < 64; f++) begin
            logic [7:0] a, b, fm;
            fm = 8'(f);
            a  = 8'((f * 37 + 5) & 8'hFF);
            b  = ~a;
            wait_idle(t0);
            wr(3'd3, fm);
            rd(3'd3, rv);
            chk(rv == fm, "R2 readback", rv, fm);
            wr(3'd0, a);
            chk(thr_empty == 1'b0, "R4 fill", thr_empty, 0);
            wait_empty(t0);
            chk(txd == 1'b0, "R10 start on take", txd, 0);
            wr(3'd0, b);
            check_bits(fm, a, 1);
            wait_fall(t1);
            chk(t1 - t0 == frame_len(fm), "R8 R10 spacing", t1 - t0, frame_len(fm));
            check_bits(fm, b, 0);
            wait_idle(t2);
            chk(t2 - t1 == frame_len(fm), "R8 length", t2 - t1, frame_len(fm));
            chk(txd == 1'b1, "R12 after frame", txd, 1);
        end

        // R9 break mid-character, R11 format captured at start
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h55);
        wait_empty(t0);
        wr(3'd3, 8'h5B);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(txd == 1'b0, "R9 break holds", txd, 0);
        end
        wr(3'd3, 8'h1B);
        wait_idle(t1);
        chk(t1 - t0 == 160, "R9 R11 timing", t1 - t0, 160);
        wr(3'd0, 8'hC6);
        wait_empty(t0);
        check_bits(8'h1B, 8'hC6, 0);
        wait_idle(t1);
        chk(t1 - t0 == frame_len(8'h1B), "R11 new format", t1 - t0, frame_len(8'h1B));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule